// File: doc/BRIEF.md
# Fast FIFO Transfer Strobe Controller

This block sits between a microcontroller's external-data bus and an endpoint FIFO. It lets a single CPU bus cycle move one byte straight between an external byte-wide device and the FIFO, so the byte never passes through the CPU. A control register enables the fast path separately for the isochronous FIFO and the bulk FIFO. The same register sets the polarity and timing mode of two strobes that pace the external device.

When the fast path is enabled for the addressed FIFO, a CPU write to that FIFO's data address starts a four-clock transfer. During it the CPU write data is ignored, a read strobe is pulsed to the external device, and the byte on the external data pins is written into the FIFO. A CPU read from an enabled FIFO address works the other way. It pops a byte from the FIFO, holds it on the external output pins and pulses a write strobe. The CPU receives zero for that read. When the fast path is disabled, FIFO accesses pass straight through with CPU data and no strobe.

Top module: `fast_xfer_strobe`

## Requirements
- R1: After reset the control register reads back as 0x00, `busy` is low and both strobes are high, because both are active low when the register is zero.
- R2: Control register fields: bit 7 enables the fast path for the isochronous FIFO and bit 6 for the bulk FIFO. Bit 5 is the read strobe polarity and bits 4:3 its timing mode. Bit 2 is the write strobe polarity and bits 1:0 its timing mode. A write at `CTRL_ADDR` updates the register and a read there returns it.
- R3: Outside a fast transfer, each strobe sits at the inverse of its polarity bit.
- R4: A fast write asserts `fifo_we` exactly once, in the last clock in which the read strobe is active. In that clock `fifo_wdata` equals `ext_din`, and `cpu_wdata` is ignored.
- R5: A fast transfer occupies the four clocks after the accepting edge, with `busy` high in each. Strobe active clocks (phase 0..3) per mode: mode 0 in phase 1 only, mode 1 in phases 0-1, mode 2 in phases 2-3, mode 3 in all four.
- R6: A fast read asserts `fifo_re` in the accepting cycle and returns 0 on `cpu_rdata`. It then holds the popped byte on `ext_dout` with `ext_doe` high for all four phases, and shapes the write strobe by the write mode.
- R7: The isochronous enable affects only `ISO_ADDR`, and the bulk enable affects only `BULK_ADDR`.
- R8: A FIFO access without the fast path asserts `fifo_we` (with `cpu_wdata`) or `fifo_re` (with `fifo_rdata` on `cpu_rdata`) in the same cycle. It drives no strobe and does not raise `busy`.
- R9: CPU accesses presented while `busy` is high are ignored. This includes control register writes.
- R10: A strobe's active level equals its polarity bit, where 1 means active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU external-data address |
| cpu_wr | input | 1 | CPU write request, one cycle |
| cpu_rd | input | 1 | CPU read request, one cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| busy | output | 1 | Fast transfer in progress; CPU must wait |
| fifo_we | output | 1 | FIFO write enable |
| fifo_re | output | 1 | FIFO read (pop) enable |
| fifo_sel | output | 1 | Selected FIFO: 0 isochronous, 1 bulk |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_rdata | input | 8 | FIFO head byte (show-ahead) |
| ext_din | input | 8 | External data pins, inbound |
| ext_dout | output | 8 | External data pins, outbound |
| ext_doe | output | 1 | External data output enable |
| rd_strb | output | 1 | Read strobe to external device |
| wr_strb | output | 1 | Write strobe to external device |

## Verification
The assertions take for granted that the CPU holds off while `busy` is high. They also assume `ext_din` is valid in the strobe's last active clock and that the FIFO offers its head byte combinationally. The stimulus presents requests only as single-cycle pulses on falling edges. It drives the correct external byte only in the expected sampling phase and junk elsewhere, so sampling in the wrong clock is caught. It deliberately issues a control write during a transfer to show that the write is dropped.

// File: rtl/fast_xfer_strobe.sv
module fast_xfer_strobe #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0040,
  parameter logic [ADDR_W-1:0] ISO_ADDR  = 16'h0010,
  parameter logic [ADDR_W-1:0] BULK_ADDR = 16'h0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              busy,
  output logic              fifo_we,
  output logic              fifo_re,
  output logic              fifo_sel,
  output logic [7:0]        fifo_wdata,
  input  logic [7:0]        fifo_rdata,
  input  logic [7:0]        ext_din,
  output logic [7:0]        ext_dout,
  output logic              ext_doe,
  output logic              rd_strb,
  output logic              wr_strb
);
  localparam int PHASES  = 4;
  localparam int PH_W    = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [7:0]      ctrl;
  logic            dir_out;
  logic            sel_q;
  logic [PH_W-1:0] phase;
  logic [7:0]      dout_q;

  wire       en_iso   = ctrl[7];
  wire       en_blk   = ctrl[6];
  wire       rpol     = ctrl[5];
  wire [1:0] rmode    = ctrl[4:3];
  wire       wpol     = ctrl[2];
  wire [1:0] wmode    = ctrl[1:0];

  wire hit_iso  = (cpu_addr == ISO_ADDR);
  wire hit_blk  = (cpu_addr == BULK_ADDR);
  wire hit_fifo = hit_iso | hit_blk;
  wire hit_ctrl = (cpu_addr == CTRL_ADDR);
  wire fast_hit = (hit_iso & en_iso) | (hit_blk & en_blk);

  wire start_fw = !busy & cpu_wr & fast_hit;
  wire start_fr = !busy & cpu_rd & fast_hit;
  wire norm_we  = !busy & cpu_wr & hit_fifo & !fast_hit;
  wire norm_re  = !busy & cpu_rd & hit_fifo & !fast_hit;
  wire ctrl_we  = !busy & cpu_wr & hit_ctrl;

  function automatic logic mode_active(input logic [1:0] m, input logic [PH_W-1:0] p);
    case (m)
      2'd0:    return p == PH_W'(1);
      2'd1:    return p < PH_W'(2);
      2'd2:    return p >= PH_W'(2);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [PH_W-1:0] mode_last(input logic [1:0] m);
    return m[1] ? PH_LAST : PH_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      busy    <= 1'b0;
      dir_out <= 1'b0;
      sel_q   <= 1'b0;
      phase   <= '0;
      dout_q  <= '0;
    end else begin
      if (ctrl_we) ctrl <= cpu_wdata;
      if (start_fw | start_fr) begin
        busy    <= 1'b1;
        phase   <= '0;
        dir_out <= start_fr;
        sel_q   <= hit_blk;
        if (start_fr) dout_q <= fifo_rdata;
      end else if (busy) begin
        if (phase == PH_LAST) busy <= 1'b0;
        phase <= phase + PH_W'(1);
      end
    end
  end

  wire rd_on   = busy & !dir_out & mode_active(rmode, phase);
  wire wr_on   = busy &  dir_out & mode_active(wmode, phase);
  wire fast_we = busy & !dir_out & (phase == mode_last(rmode));

  assign rd_strb    = rd_on ? rpol : ~rpol;
  assign wr_strb    = wr_on ? wpol : ~wpol;
  assign fifo_we    = norm_we | fast_we;
  assign fifo_wdata = busy ? ext_din : cpu_wdata;
  assign fifo_re    = norm_re | start_fr;
  assign fifo_sel   = busy ? sel_q : hit_blk;
  assign ext_doe    = busy & dir_out;
  assign ext_dout   = dout_q;
  assign cpu_rdata  = hit_ctrl ? ctrl : (norm_re ? fifo_rdata : 8'h00);

  assert_strobe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_strb == ~ctrl[5]) && (wr_strb == ~ctrl[2]));

  assert_sample_under_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && busy) |-> (rd_strb == ctrl[5]) && (fifo_wdata == ext_din));

  assert_busy_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy);

  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_doe && $past(ext_doe)) |-> $stable(ext_dout));

  assert_no_write_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_doe |-> !fifo_we && (rd_strb == ~ctrl[5]));

  assert_plain_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && !busy) |=> !busy);

  assert_ctrl_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl));
endmodule

// File: tb/fast_xfer_strobe_tb.sv
module fast_xfer_strobe_tb;
  localparam logic [15:0] CA = 16'h0040, IA = 16'h0010, BA = 16'h0020;

  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [7:0] cpu_wdata = '0, fifo_rdata = '0, ext_din = '0;
  logic [7:0] cpu_rdata, fifo_wdata, ext_dout;
  logic busy, fifo_we, fifo_re, fifo_sel, ext_doe, rd_strb, wr_strb;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  fast_xfer_strobe u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy), .fifo_we(fifo_we),
    .fifo_re(fifo_re), .fifo_sel(fifo_sel), .fifo_wdata(fifo_wdata),
    .fifo_rdata(fifo_rdata), .ext_din(ext_din), .ext_dout(ext_dout),
    .ext_doe(ext_doe), .rd_strb(rd_strb), .wr_strb(wr_strb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pat(input int m, input int p);
    case (m)
      0: return p == 1;
      1: return p < 2;
      2: return p >= 2;
      default: return 1;
    endcase
  endfunction

  // scoreboard monitor: pops one expected byte per FIFO write
  initial forever begin
    @(negedge clk); #3;
    if (rst_n && fifo_we) begin
      if (exp_q.size() == 0) chk(0, "R4/R8/R9 unexpected fifo_we", fifo_wdata, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(fifo_wdata == e, "R4/R8 fifo_wdata", fifo_wdata, e);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic ctrl_wr(input logic [7:0] v);
    @(negedge clk); cpu_addr = CA; cpu_wr = 1; cpu_wdata = v;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic ctrl_rd(input logic [7:0] e, input string req);
    @(negedge clk); cpu_addr = CA; cpu_rd = 1; #3;
    chk(cpu_rdata == e, req, cpu_rdata, e);
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic plain_wr(input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk); cpu_addr = a; cpu_wr = 1; cpu_wdata = d; exp_q.push_back(d); #3;
    chk(fifo_we == 1 && busy == 0, req, {fifo_we, busy}, 2'b10);
    @(negedge clk); cpu_wr = 0; #3;
    chk(busy == 0, req, busy, 0);
  endtask

  task automatic fast_wr(input logic [15:0] a, input logic [7:0] d, input int m,
                         input bit pol, input bit poke);
    int last;
    last = (m >= 2) ? 3 : 1;
    @(negedge clk); cpu_addr = a; cpu_wr = 1; cpu_wdata = ~d; ext_din = 8'h5A;
    exp_q.push_back(d);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      cpu_wr = 0;
      ext_din = (p == last) ? d : ~d;
      if (poke && p == 1) begin cpu_addr = CA; cpu_wr = 1; cpu_wdata = 8'hFF; end
      if (poke && p == 2) begin cpu_addr = a; cpu_wr = 0; end
      #3;
      chk(busy == 1, "R5 busy during phase", busy, 1);
      chk(rd_strb == (pat(m, p) ? pol : ~pol), "R5/R10 rd_strb shape", rd_strb, pat(m, p) ? pol : ~pol);
    end
    @(negedge clk); #3;
    chk(busy == 0, "R5 busy ends after four phases", busy, 0);
    chk(rd_strb == ~pol, "R3 rd_strb back idle", rd_strb, ~pol);
  endtask

  task automatic fast_rd(input logic [15:0] a, input logic [7:0] d, input int m, input bit wpol);
    @(negedge clk); cpu_addr = a; cpu_rd = 1; fifo_rdata = d; #3;
    chk(fifo_re == 1, "R6 fifo_re at accept", fifo_re, 1);
    chk(cpu_rdata == 0, "R6 cpu_rdata cut off", cpu_rdata, 0);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); cpu_rd = 0; fifo_rdata = ~d; #3;
      chk(ext_doe == 1 && ext_dout == d, "R6 ext_dout held", ext_dout, d);
      chk(wr_strb == (pat(m, p) ? wpol : ~wpol), "R6/R10 wr_strb shape", wr_strb, pat(m, p) ? wpol : ~wpol);
    end
    @(negedge clk); #3;
    chk(ext_doe == 0 && busy == 0, "R6 transfer done", {ext_doe, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(busy == 0, "R1 busy reset", busy, 0);
    chk(rd_strb == 1 && wr_strb == 1, "R1/R3 idle strobes high", {rd_strb, wr_strb}, 2'b11);
    ctrl_rd(8'h00, "R1 ctrl resets to zero");

    plain_wr(IA, 8'h11, "R8 plain write iso");
    @(negedge clk); cpu_addr = IA; cpu_rd = 1; fifo_rdata = 8'h3C; #3;
    chk(fifo_re == 1 && cpu_rdata == 8'h3C, "R8 plain read", cpu_rdata, 8'h3C);
    @(negedge clk); cpu_rd = 0;

    for (int m = 0; m < 4; m++) begin
      logic [7:0] v;
      v = 8'h80 | 8'(m << 3) | 8'h04 | 8'(m);
      ctrl_wr(v);
      ctrl_rd(v, "R2 ctrl readback");
      @(negedge clk); #3;
      chk(rd_strb == 1 && wr_strb == 0, "R3 idle is inverse of polarity", {rd_strb, wr_strb}, 2'b10);
      fast_wr(IA, 8'hA0 + 8'(m), m, 0, 0);
      fast_rd(IA, 8'hC0 + 8'(m), m, 1);
    end

    ctrl_wr(8'hB0);
    fast_wr(IA, 8'h77, 2, 1, 1);
    ctrl_rd(8'hB0, "R9 ctrl write during busy ignored");

    ctrl_wr(8'h40);
    plain_wr(IA, 8'h22, "R7 iso address not fast under bulk enable");
    fast_wr(BA, 8'h99, 0, 0, 0);
    ctrl_wr(8'h80);
    plain_wr(BA, 8'h33, "R7 bulk address not fast under iso enable");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected FIFO writes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule